// File: doc/BRIEF.md
# Exception Escalation Controller

This block decides what the core does when something interrupts normal execution. It takes requests from three kinds of source: external hardware interrupt lines, a software interrupt instruction that carries its own vector number, and synchronous exceptions raised while an instruction executes. Two exception kinds are detected inside the block. One is a taken branch or jump to a target that is not word aligned. The other is a divide-by-zero flag from the divider. A third input accepts any other exception, with its own vector and error code.

From its current level of nesting, the controller either keeps the core running, enters a handler, escalates to a double fault, or requests a processor reset. There are three escalation levels. A fault inside a normal handler becomes a double fault. A fault inside the double fault is unrecoverable and produces a one-cycle reset request, after which the controller is back in the running state with cleared outputs. A return-from-interrupt input leaves either handler level. A programmable cycle watchdog detects a handler that never returns and treats that as a fault at the current level.

Each accepted event produces a one-cycle handler-entry pulse, a vector number and a 32-bit error code. An error code of 0 means the event carries no error information. Descriptor-table lookup, context saving and paging belong to other blocks.

Top module: `exc_escalation_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (running), `vec_o` and `err_code_o` are 0, and `enter_o` and `reset_req_o` are low. The state encoding is 0 running, 1 handler, 2 double fault, 3 reset.
- R2: In the running state, any accepted event moves the state to handler at the next clock edge. `enter_o` is high for that one cycle, and the vector and error code of the event are latched. Software and hardware interrupts latch an error code of 0.
- R3: When several requests arrive in one cycle, a synchronous exception beats the software interrupt, and the software interrupt beats the hardware lines. Among the hardware lines the lowest index wins, with vector HW_VEC_BASE (default 32) plus that index.
- R4: A branch with `br_valid` and `br_taken` high whose target has bits [1:0] not equal to 0 raises an alignment exception. It has vector ALIGN_VEC (default 17), and its error code is the target address. A branch that is not taken, or that is aligned, raises nothing.
- R5: `div_zero` raises an exception with vector DIVZ_VEC (default 0) and error code 0. Among the synchronous sources, alignment wins over divide-by-zero, and divide-by-zero wins over the generic `exc_valid` input.
- R6: In the handler state, software and hardware interrupts are ignored. `iret` with no fault returns to running and keeps `vec_o` and `err_code_o`.
- R7: Any synchronous exception in the handler state moves the state to double fault. `vec_o` becomes DF_VEC (default 8), the error code of the fault is latched, and `enter_o` pulses.
- R8: In the double-fault state, `iret` with no fault returns to running.
- R9: Any fault in the double-fault state moves the state to reset, with `reset_req_o` high for exactly one cycle. The next cycle returns to running with `vec_o` and `err_code_o` cleared to 0. Inputs are ignored in the reset state.
- R10: When `wd_limit` is L, with L not 0, staying in the handler or double-fault state for L+1 clock edges without leaving counts as a fault with error code 0. When `wd_limit` is 0, the watchdog is off.
- R11: When a fault and `iret` arrive in the same cycle, the fault wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | IRQ_N (4) | Hardware interrupt request lines |
| sw_int | input | 1 | Software interrupt instruction strobe |
| sw_vec | input | VEC_W (8) | Vector number carried by the software interrupt |
| exc_valid | input | 1 | Generic synchronous exception strobe |
| exc_vec | input | VEC_W (8) | Vector of the generic exception |
| exc_code | input | 32 | Error code of the generic exception |
| div_zero | input | 1 | Divide-by-zero flag from the divider |
| br_valid | input | 1 | A branch or jump is resolving this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| br_target | input | ADDR_W (32) | Target address of the resolving branch |
| iret | input | 1 | Return from the current handler |
| wd_limit | input | WD_W (8) | Handler watchdog limit in cycles; 0 turns it off |
| state_o | output | 2 | Escalation state (0 run, 1 handler, 2 double fault, 3 reset) |
| vec_o | output | VEC_W (8) | Selected vector |
| err_code_o | output | 32 | Latched error code |
| enter_o | output | 1 | One-cycle handler-entry pulse |
| reset_req_o | output | 1 | One-cycle processor reset request |

## Verification
The bench builds the block with its default parameters. IRQ_N is 4, so every hardware line and every lowest-index tie can be driven. VEC_W is 8, so a software vector such as 0x55 is distinct from all fixed vectors. WD_W is 8, so a small watchdog limit such as 3 or 6 makes timeouts in both handler levels, and the chained escalation into reset, happen within a few cycles. In the random phase the limit is 6, which sits between the typical gaps of the sparse random faults and `iret` strobes. That mix brings both returns and watchdog escalations into the same run.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int ERR_W = 32;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HANDLER = 2'd1,
    ST_DFAULT  = 2'd2,
    ST_RESET   = 2'd3
  } esc_state_e;
endpackage

// File: rtl/esc_arbiter.sv
module esc_arbiter
  import esc_pkg::*;
#(
  parameter int IRQ_N       = 4,
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_VEC   = 17,
  parameter int DIVZ_VEC    = 0,
  parameter int HW_VEC_BASE = 32
) (
  input  logic [IRQ_N-1:0]  hw_irq,
  input  logic              sw_int,
  input  logic [VEC_W-1:0]  sw_vec,
  input  logic              exc_valid,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic [ERR_W-1:0]  exc_code,
  input  logic              div_zero,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic              sync_hit,
  output logic [VEC_W-1:0]  sync_vec,
  output logic [ERR_W-1:0]  sync_code,
  output logic              async_hit,
  output logic [VEC_W-1:0]  async_vec
);
  localparam logic [VEC_W-1:0] ALIGN_V = VEC_W'(ALIGN_VEC);
  localparam logic [VEC_W-1:0] DIVZ_V  = VEC_W'(DIVZ_VEC);

  logic             misalign;
  logic             hw_hit;
  logic [VEC_W-1:0] hw_vec;

  // Alignment check: only a taken branch can fault.
  assign misalign = br_valid & br_taken & (br_target[1:0] != 2'b00);

  always_comb begin
    sync_hit  = misalign | div_zero | exc_valid;
    sync_vec  = exc_vec;
    sync_code = exc_code;
    if (misalign) begin
      sync_vec  = ALIGN_V;
      sync_code = ERR_W'(br_target);
    end else if (div_zero) begin
      sync_vec  = DIVZ_V;
      sync_code = '0;
    end
  end

  // Lowest-index hardware line wins: scan from the top down.
  always_comb begin
    hw_hit = |hw_irq;
    hw_vec = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (hw_irq[i]) hw_vec = VEC_W'(HW_VEC_BASE + i);
    end
  end

  assign async_hit = sw_int | hw_hit;
  assign async_vec = sw_int ? sw_vec : hw_vec;
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog #(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            restart,
  input  logic [WD_W-1:0] limit,
  output logic            timeout
);
  logic [WD_W-1:0] cnt_q;
  logic [WD_W-1:0] cnt_d;

  always_comb begin
    if (restart || !busy) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timeout = busy && (limit != '0) && (cnt_q >= limit);

  // R10
  wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !timeout);

  // R10
  wd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> busy);
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
  import esc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_hit,
  input  logic [VEC_W-1:0] sync_vec,
  input  logic [ERR_W-1:0] sync_code,
  input  logic             async_hit,
  input  logic [VEC_W-1:0] async_vec,
  input  logic             iret,
  input  logic             timeout,
  output esc_state_e       state_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [ERR_W-1:0] code_q,
  output logic             enter_q,
  output logic             busy,
  output logic             restart
);
  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  esc_state_e       state_d;
  logic [VEC_W-1:0] vec_d;
  logic [ERR_W-1:0] code_d;
  logic             load_en;
  logic             enter_d;
  logic             fault;
  logic [ERR_W-1:0] fault_code;

  assign fault      = sync_hit | timeout;
  assign fault_code = sync_hit ? sync_code : '0;
  assign busy       = (state_q == ST_HANDLER) || (state_q == ST_DFAULT);
  assign restart    = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    vec_d   = vec_q;
    code_d  = code_q;
    load_en = 1'b0;
    enter_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sync_hit) begin
          state_d = ST_HANDLER;
          vec_d   = sync_vec;
          code_d  = sync_code;
          load_en = 1'b1;
          enter_d = 1'b1;
        end else if (async_hit) begin
          state_d = ST_HANDLER;
          vec_d   = async_vec;
          code_d  = '0;
          load_en = 1'b1;
          enter_d = 1'b1;
        end
      end
      ST_HANDLER: begin
        if (fault) begin
          state_d = ST_DFAULT;
          vec_d   = DF_V;
          code_d  = fault_code;
          load_en = 1'b1;
          enter_d = 1'b1;
        end else if (iret) begin
          state_d = ST_RUN;
        end
      end
      ST_DFAULT: begin
        if (fault)     state_d = ST_RESET;
        else if (iret) state_d = ST_RUN;
      end
      ST_RESET: begin
        state_d = ST_RUN;
        vec_d   = '0;
        code_d  = '0;
        load_en = 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      enter_q <= 1'b0;
    end else begin
      state_q <= state_d;
      enter_q <= enter_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      code_q <= '0;
    end else if (load_en) begin
      vec_q  <= vec_d;
      code_q <= code_d;
    end
  end

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && (sync_hit || async_hit)) |=> (state_q == ST_HANDLER && enter_q));

  // R6
  handler_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HANDLER && iret && !sync_hit && !timeout) |=> (state_q == ST_RUN && $stable(code_q)));

  // R7
  df_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HANDLER && sync_hit) |=> (state_q == ST_DFAULT && vec_q == DF_V && enter_q));

  // R8
  df_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DFAULT && iret && !fault) |=> (state_q == ST_RUN));

  // R9
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET) |=> (state_q == ST_RUN && code_q == '0 && vec_q == '0));

  // R11
  fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DFAULT && fault && iret) |=> (state_q == ST_RESET));
endmodule

// File: rtl/exc_escalation_ctrl.sv
module exc_escalation_ctrl
  import esc_pkg::*;
#(
  parameter int IRQ_N       = 4,
  parameter int VEC_W       = 8,
  parameter int ADDR_W      = 32,
  parameter int WD_W        = 8,
  parameter int ALIGN_VEC   = 17,
  parameter int DIVZ_VEC    = 0,
  parameter int DF_VEC      = 8,
  parameter int HW_VEC_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  hw_irq,
  input  logic              sw_int,
  input  logic [VEC_W-1:0]  sw_vec,
  input  logic              exc_valid,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic [31:0]       exc_code,
  input  logic              div_zero,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              iret,
  input  logic [WD_W-1:0]   wd_limit,
  output logic [1:0]        state_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [31:0]       err_code_o,
  output logic              enter_o,
  output logic              reset_req_o
);
  logic             sync_hit;
  logic [VEC_W-1:0] sync_vec;
  logic [ERR_W-1:0] sync_code;
  logic             async_hit;
  logic [VEC_W-1:0] async_vec;
  logic             timeout;
  logic             busy;
  logic             restart;
  esc_state_e       state_q;

  esc_arbiter #(
    .IRQ_N(IRQ_N), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .ALIGN_VEC(ALIGN_VEC), .DIVZ_VEC(DIVZ_VEC), .HW_VEC_BASE(HW_VEC_BASE)
  ) u_arb (
    .hw_irq(hw_irq), .sw_int(sw_int), .sw_vec(sw_vec),
    .exc_valid(exc_valid), .exc_vec(exc_vec), .exc_code(exc_code),
    .div_zero(div_zero), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target),
    .sync_hit(sync_hit), .sync_vec(sync_vec), .sync_code(sync_code),
    .async_hit(async_hit), .async_vec(async_vec)
  );

  esc_watchdog #(.WD_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .restart(restart),
    .limit(wd_limit), .timeout(timeout)
  );

  esc_fsm #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sync_hit(sync_hit), .sync_vec(sync_vec), .sync_code(sync_code),
    .async_hit(async_hit), .async_vec(async_vec),
    .iret(iret), .timeout(timeout),
    .state_q(state_q), .vec_q(vec_o), .code_q(err_code_o),
    .enter_q(enter_o), .busy(busy), .restart(restart)
  );

  assign state_o     = state_q;
  assign reset_req_o = (state_q == ST_RESET);

  // R9
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> (!reset_req_o && state_o == 2'd0));
endmodule

// File: tb/tb_exc_escalation_ctrl.sv
`timescale 1ns/1ps
module tb_exc_escalation_ctrl;
  localparam int B_ALIGN = 17;
  localparam int B_DIVZ  = 0;
  localparam int B_DF    = 8;
  localparam int B_HW    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_irq;
  logic        sw_int;
  logic [7:0]  sw_vec;
  logic        exc_valid;
  logic [7:0]  exc_vec;
  logic [31:0] exc_code;
  logic        div_zero;
  logic        br_valid;
  logic        br_taken;
  logic [31:0] br_target;
  logic        iret;
  logic [7:0]  wd_limit;
  logic [1:0]  state_o;
  logic [7:0]  vec_o;
  logic [31:0] err_code_o;
  logic        enter_o;
  logic        reset_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected model
  logic [1:0]  m_state;
  logic [7:0]  m_vec;
  logic [31:0] m_code;
  logic        m_enter;
  logic [7:0]  m_cnt;
  string       m_tag;

  always #2.5 clk = ~clk;

  exc_escalation_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .sw_int(sw_int), .sw_vec(sw_vec),
    .exc_valid(exc_valid), .exc_vec(exc_vec), .exc_code(exc_code),
    .div_zero(div_zero), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .iret(iret), .wd_limit(wd_limit),
    .state_o(state_o), .vec_o(vec_o), .err_code_o(err_code_o),
    .enter_o(enter_o), .reset_req_o(reset_req_o)
  );

  function automatic logic [7:0] lowest_hw(input logic [3:0] l);
    for (int i = 0; i < 4; i++) if (l[i]) return 8'(B_HW + i);
    return 8'd0;
  endfunction

  task automatic idle();
    hw_irq = '0; sw_int = 0; sw_vec = '0; exc_valid = 0; exc_vec = '0;
    exc_code = '0; div_zero = 0; br_valid = 0; br_taken = 0; br_target = '0;
    iret = 0;
  endtask

  task automatic model_step();
    logic        mis, shit, busy, tmo, fault;
    logic [7:0]  svec;
    logic [31:0] scode;
    logic [1:0]  nst;
    mis   = br_valid && br_taken && (br_target[1:0] != 2'b00);
    shit  = mis || div_zero || exc_valid;
    svec  = mis ? 8'(B_ALIGN) : div_zero ? 8'(B_DIVZ) : exc_vec;
    scode = mis ? br_target : div_zero ? 32'd0 : exc_code;
    busy  = (m_state == 2'd1) || (m_state == 2'd2);
    tmo   = busy && (wd_limit != 0) && (m_cnt >= wd_limit);
    fault = shit || tmo;
    nst = m_state; m_enter = 0; m_tag = "R2";
    case (m_state)
      2'd0: begin
        if (shit) begin
          nst = 1; m_vec = svec; m_code = scode; m_enter = 1; m_tag = "R3";
        end else if (sw_int) begin
          nst = 1; m_vec = sw_vec; m_code = 0; m_enter = 1; m_tag = "R3";
        end else if (hw_irq != 0) begin
          nst = 1; m_vec = lowest_hw(hw_irq); m_code = 0; m_enter = 1; m_tag = "R2";
        end
      end
      2'd1: begin
        if (fault) begin
          nst = 2; m_vec = 8'(B_DF); m_code = shit ? scode : 32'd0; m_enter = 1;
          m_tag = shit ? "R7" : "R10";
        end else if (iret) begin
          nst = 0; m_tag = "R6";
        end else m_tag = "R6";
      end
      2'd2: begin
        if (fault) begin nst = 3; m_tag = shit ? "R9" : "R10"; end
        else if (iret) begin nst = 0; m_tag = "R8"; end
        else m_tag = "R8";
      end
      default: begin nst = 0; m_vec = 0; m_code = 0; m_tag = "R9"; end
    endcase
    m_cnt   = (nst != m_state) ? 8'd0 : (busy ? m_cnt + 8'd1 : 8'd0);
    m_state = nst;
  endtask

  task automatic check(input string tag);
    logic rr;
    rr = (m_state == 2'd3);
    checks++;
    if (state_o !== m_state || vec_o !== m_vec || err_code_o !== m_code ||
        enter_o !== m_enter || reset_req_o !== rr) begin
      fails++;
      $display("FAIL %s: actual st=%0d vec=%0h code=%0h ent=%0b rr=%0b expected st=%0d vec=%0h code=%0h ent=%0b rr=%0b",
               tag, state_o, vec_o, err_code_o, enter_o, reset_req_o,
               m_state, m_vec, m_code, m_enter, rr);
    end
  endtask

  // Inputs are set at a falling edge; the next falling edge sees the result.
  task automatic cycle(input string tag);
    model_step();
    @(negedge clk);
    check(tag);
    idle();
  endtask

  task automatic rcycle();
    model_step();
    @(negedge clk);
    check(m_tag);
    idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    idle();
    wd_limit = 8'd0;
    m_state = 0; m_vec = 0; m_code = 0; m_enter = 0; m_cnt = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R3 lowest hardware line wins
    hw_irq = 4'b0110; cycle("R3");
    checks++;
    if (vec_o !== 8'd33) begin fails++; $display("FAIL R3: actual vec=%0h expected vec=21", vec_o); end
    iret = 1; cycle("R6");
    // R3 software over hardware
    sw_int = 1; sw_vec = 8'h55; hw_irq = 4'b0001; cycle("R3");
    iret = 1; cycle("R6");
    // R3 exception over software
    exc_valid = 1; exc_vec = 8'h0E; exc_code = 32'hDEAD; sw_int = 1; sw_vec = 8'h55; cycle("R3");
    iret = 1; cycle("R6");
    // R4 not taken and aligned branches raise nothing
    br_valid = 1; br_taken = 0; br_target = 32'h1003; cycle("R4");
    br_valid = 1; br_taken = 1; br_target = 32'h1000; cycle("R4");
    // R4 misaligned taken branch beats divide and generic
    br_valid = 1; br_taken = 1; br_target = 32'h2002; div_zero = 1; exc_valid = 1;
    exc_vec = 8'h30; exc_code = 32'h1; cycle("R4");
    iret = 1; cycle("R6");
    // R5 divide over generic
    div_zero = 1; exc_valid = 1; exc_vec = 8'h30; exc_code = 32'h7; cycle("R5");
    // R6 interrupts ignored in handler
    hw_irq = 4'hF; sw_int = 1; sw_vec = 8'h44; cycle("R6");
    // R11 fault beats iret
    iret = 1; exc_valid = 1; exc_vec = 8'h22; exc_code = 32'hBEEF; cycle("R11");
    checks++;
    if (state_o !== 2'd2) begin fails++; $display("FAIL R11: actual st=%0d expected st=2", state_o); end
    // R8 return from double fault
    iret = 1; cycle("R8");
    // R7 / R9 full escalation
    hw_irq = 4'b1000; cycle("R2");
    exc_valid = 1; exc_code = 32'h0BAD; cycle("R7");
    div_zero = 1; cycle("R9");
    checks++;
    if (reset_req_o !== 1'b1) begin fails++; $display("FAIL R9: actual rr=%0b expected rr=1", reset_req_o); end
    sw_int = 1; sw_vec = 8'h12; cycle("R9");
    cycle("R9");
    // R10 watchdog escalates twice
    wd_limit = 8'd3;
    hw_irq = 4'b0100; cycle("R10");
    for (int k = 0; k < 9; k++) cycle("R10");
    // R10 disabled watchdog
    wd_limit = 8'd0;
    sw_int = 1; sw_vec = 8'h66; cycle("R10");
    for (int k = 0; k < 20; k++) cycle("R10");
    iret = 1; cycle("R6");

    // random phase
    wd_limit = 8'd6;
    for (int n = 0; n < 4000; n++) begin
      hw_irq    = ($urandom % 8 == 0) ? 4'($urandom) : 4'd0;
      sw_int    = ($urandom % 10 == 0);
      sw_vec    = 8'($urandom);
      exc_valid = ($urandom % 14 == 0);
      exc_vec   = 8'($urandom);
      exc_code  = $urandom;
      div_zero  = ($urandom % 25 == 0);
      br_valid  = ($urandom % 4 == 0);
      br_taken  = $urandom % 2;
      br_target = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'hFFFF_FFFC);
      iret      = ($urandom % 6 == 0);
      rcycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : seed
    int unsigned s;
    s = $urandom(32'd1234);
  end
endmodule